// File: doc/BRIEF.md
# Paged Address Translator with Tagged Lookup Buffer

This block turns a logical address from a processor into a physical address under a paging scheme. The low bits of the logical address are the byte offset inside a page, and the high bits are the page number. A small, fully associative lookup buffer holds recent translations. Each buffer entry is tagged with an address-space identifier. When the page number and the current identifier match an entry, the physical address is formed in the same cycle, with no memory access.

When nothing matches, the block walks a single-level page table held in memory. It issues exactly one read, at the table base register plus the page number. It checks the returned entry and, if the entry is usable, writes it into the buffer over the victim chosen by a rotating pointer. A page number at or beyond the table length register is rejected at once with a fault and no read. A table entry whose valid bit is clear also ends in a fault. Software handles faults; this block only flags them. Only one walk is in flight at a time, and the request port holds ready low until the walk's response has been given.

Top module: `page_xlate`

## Requirements
- R1: The physical address of a successful translation is {frame, offset}. The low PAGE_W bits of the logical address pass through unchanged.
- R2: A request whose page number and current identifier match a valid buffer entry is answered in the same cycle with rsp_valid=1, rsp_hit=1 and rsp_fault=0. It causes no memory read.
- R3: On a miss, exactly one read is issued, as a one-cycle mem_req pulse in the cycle after acceptance, at address base + page number. req_ready stays low from acceptance until the cycle in which mem_rsp_valid returns; that cycle carries the response with rsp_hit=0.
- R4: A request whose page number is greater than or equal to the length register is answered in the same cycle with rsp_fault=1 and rsp_hit=0. No memory read follows. After reset the length register is 0.
- R5: A table entry's bit 0 is its valid bit, and bits PTE_W-1:1 hold the frame. A returned entry with bit 0 clear gives rsp_fault=1 and is not stored, so the next request to that page misses again.
- R6: A returned entry with bit 0 set is stored, and the next request to the same page and identifier hits. No key is ever held by two valid entries.
- R7: An entry hits only when its stored identifier equals cfg_asid. The same page under another identifier misses.
- R8: A one-cycle flush pulse invalidates every buffer entry.
- R9: A write to the base register or to the length register also invalidates every buffer entry.
- R10: Refills replace entries in rotating order. The victim pointer advances by one per refill, wraps after ENTRIES, and is not moved by flushes. The ENTRIES+1-th distinct page refilled after a flush evicts the first.
- R11: A flush or register write made while a walk is in flight still lets the walk's response through, but the entry it returns is not stored.
- R12: After reset, req_ready=1, rsp_valid=0, mem_req=0 and the buffer is empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Translation request present |
| req_ready | output | 1 | Block can accept a request (low during a walk) |
| req_vaddr | input | VA_W | Logical address |
| cfg_asid | input | ASID_W | Current address-space identifier |
| rsp_valid | output | 1 | Response present this cycle |
| rsp_paddr | output | PA_W | Physical address (zero on fault) |
| rsp_hit | output | 1 | Answer came from the lookup buffer |
| rsp_fault | output | 1 | Translation failed |
| mem_req | output | 1 | One-cycle page-table read strobe |
| mem_addr | output | MA_W | Page-table read address |
| mem_rsp_valid | input | 1 | Read data returned |
| mem_rsp_data | input | PTE_W | Page-table entry |
| flush | input | 1 | Invalidate all buffer entries |
| base_we | input | 1 | Write the table base register |
| base_wdata | input | MA_W | New table base |
| len_we | input | 1 | Write the table length register |
| len_wdata | input | VPN_W+1 | New table length, in entries |

## Verification
The hardest case to reach is an invalidation that lands while a walk is waiting on memory, because the stale entry must then be dropped rather than stored. The bench owns the memory side. It holds the read response back for a chosen number of cycles and pulses flush inside that window, then checks that the next request to the same page misses. Eviction order is reached by flushing and then refilling one more distinct page than the buffer holds. Random traffic over a few identifiers and a page range that straddles the length bound is then checked against a reference model in the bench.

// File: rtl/page_xlate.sv
module page_xlate #(
  parameter int VA_W    = 16,
  parameter int PAGE_W  = 8,
  parameter int PA_W    = 20,
  parameter int MA_W    = 16,
  parameter int ASID_W  = 4,
  parameter int ENTRIES = 8,
  localparam int VPN_W   = VA_W - PAGE_W,
  localparam int FRAME_W = PA_W - PAGE_W,
  localparam int PTE_W   = FRAME_W + 1,
  localparam int LEN_W   = VPN_W + 1,
  localparam int IDX_W   = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [VA_W-1:0]   req_vaddr,
  input  logic [ASID_W-1:0] cfg_asid,
  output logic              rsp_valid,
  output logic [PA_W-1:0]   rsp_paddr,
  output logic              rsp_hit,
  output logic              rsp_fault,
  output logic              mem_req,
  output logic [MA_W-1:0]   mem_addr,
  input  logic              mem_rsp_valid,
  input  logic [PTE_W-1:0]  mem_rsp_data,
  input  logic              flush,
  input  logic              base_we,
  input  logic [MA_W-1:0]   base_wdata,
  input  logic              len_we,
  input  logic [LEN_W-1:0]  len_wdata
);

  typedef enum logic [1:0] {S_IDLE, S_REQ, S_WAIT} st_t;
  st_t st_q;

  logic [MA_W-1:0]    base_q;
  logic [LEN_W-1:0]   len_q;
  logic [ENTRIES-1:0] ent_v;
  logic [VPN_W-1:0]   ent_vpn   [ENTRIES];
  logic [ASID_W-1:0]  ent_asid  [ENTRIES];
  logic [FRAME_W-1:0] ent_frame [ENTRIES];
  logic [IDX_W-1:0]   vict_q;

  logic [VPN_W-1:0]   w_vpn;
  logic [PAGE_W-1:0]  w_off;
  logic [ASID_W-1:0]  w_asid;
  logic               w_stale;

  logic [VPN_W-1:0]   req_vpn;
  logic [PAGE_W-1:0]  req_off;
  logic [ENTRIES-1:0] hit_vec;
  logic [FRAME_W-1:0] hit_frame;
  logic               any_hit, oob, inval, accept, walk_done, refill, pte_ok;

  assign req_vpn   = req_vaddr[VA_W-1:PAGE_W];
  assign req_off   = req_vaddr[PAGE_W-1:0];
  assign oob       = {1'b0, req_vpn} >= len_q;
  assign inval     = flush | base_we | len_we;
  assign req_ready = (st_q == S_IDLE);
  assign accept    = req_valid & req_ready;
  assign pte_ok    = mem_rsp_data[0];
  assign walk_done = (st_q == S_WAIT) & mem_rsp_valid;
  assign refill    = walk_done & pte_ok & ~w_stale & ~inval;

  for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
    assign hit_vec[g] = ent_v[g] & (ent_vpn[g] == req_vpn) & (ent_asid[g] == cfg_asid);
  end

  assign any_hit = |hit_vec;

  always_comb begin
    hit_frame = '0;
    for (int i = 0; i < ENTRIES; i++)
      if (hit_vec[i]) hit_frame = hit_frame | ent_frame[i];
  end

  assign mem_req  = (st_q == S_REQ);
  assign mem_addr = base_q + MA_W'(w_vpn);

  assign rsp_valid = (req_ready & req_valid & (oob | any_hit)) | walk_done;
  assign rsp_hit   = req_ready & req_valid & ~oob & any_hit;
  assign rsp_fault = (req_ready & req_valid & oob) | (walk_done & ~pte_ok);

  always_comb begin
    rsp_paddr = '0;
    if (rsp_hit)
      rsp_paddr = {hit_frame, req_off};
    else if (walk_done & pte_ok)
      rsp_paddr = {mem_rsp_data[PTE_W-1:1], w_off};
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q    <= S_IDLE;
      w_vpn   <= '0;
      w_off   <= '0;
      w_asid  <= '0;
      w_stale <= 1'b0;
    end else begin
      case (st_q)
        S_IDLE: if (accept && !oob && !any_hit) begin
          st_q    <= S_REQ;
          w_vpn   <= req_vpn;
          w_off   <= req_off;
          w_asid  <= cfg_asid;
          w_stale <= 1'b0;
        end
        S_REQ: begin
          st_q <= S_WAIT;
          if (inval) w_stale <= 1'b1;
        end
        S_WAIT: begin
          if (inval) w_stale <= 1'b1;
          if (mem_rsp_valid) st_q <= S_IDLE;
        end
        default: st_q <= S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      base_q <= '0;
      len_q  <= '0;
    end else begin
      if (base_we) base_q <= base_wdata;
      if (len_we)  len_q  <= len_wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ent_v  <= '0;
      vict_q <= '0;
    end else if (inval) begin
      ent_v <= '0;
    end else if (refill) begin
      ent_v[vict_q] <= 1'b1;
      vict_q <= (vict_q == IDX_W'(ENTRIES - 1)) ? '0 : vict_q + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (refill) begin
      ent_vpn[vict_q]   <= w_vpn;
      ent_asid[vict_q]  <= w_asid;
      ent_frame[vict_q] <= mem_rsp_data[PTE_W-1:1];
    end
  end

  p_hit_same_cycle_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && !oob && any_hit) |-> (rsp_valid && rsp_hit && !rsp_fault));

  p_no_read_after_hit_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && any_hit) |=> !mem_req);

  p_single_read_r3: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |=> !mem_req);

  p_stall_in_walk_r3: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> !req_ready);

  p_no_read_oob_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && oob) |=> (!mem_req && req_ready));

  p_unique_key_r6: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |-> ($countones(hit_vec) <= 1));

  p_flush_empties_r8: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (ent_v == '0));

  p_cfg_empties_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (base_we || len_we) |=> (ent_v == '0));

  p_stale_dropped_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (walk_done && (w_stale || inval)) |=> $stable(vict_q));

endmodule

// File: tb/page_xlate_tb_top.sv
module page_xlate_tb_top;
  localparam int VA_W = 16, PAGE_W = 8, PA_W = 20, MA_W = 16, ASID_W = 4, ENTRIES = 8;
  localparam int VPN_W = VA_W - PAGE_W, FRAME_W = PA_W - PAGE_W, PTE_W = FRAME_W + 1;
  localparam int LEN_W = VPN_W + 1;

  logic clk = 0, rst_n = 0;
  logic req_valid = 0, req_ready;
  logic [VA_W-1:0] req_vaddr = '0;
  logic [ASID_W-1:0] cfg_asid = '0;
  logic rsp_valid, rsp_hit, rsp_fault, mem_req;
  logic [PA_W-1:0] rsp_paddr;
  logic [MA_W-1:0] mem_addr;
  logic mem_rsp_valid = 0;
  logic [PTE_W-1:0] mem_rsp_data = '0;
  logic flush = 0, base_we = 0, len_we = 0;
  logic [MA_W-1:0] base_wdata = '0;
  logic [LEN_W-1:0] len_wdata = '0;

  always #2.5 clk = ~clk;

  page_xlate #(.VA_W(VA_W), .PAGE_W(PAGE_W), .PA_W(PA_W), .MA_W(MA_W),
               .ASID_W(ASID_W), .ENTRIES(ENTRIES)) dut_i (
    .clk, .rst_n, .req_valid, .req_ready, .req_vaddr, .cfg_asid,
    .rsp_valid, .rsp_paddr, .rsp_hit, .rsp_fault, .mem_req, .mem_addr,
    .mem_rsp_valid, .mem_rsp_data, .flush, .base_we, .base_wdata,
    .len_we, .len_wdata);

  int checks = 0, errors = 0;
  logic [MA_W-1:0] m_base = '0;
  logic [LEN_W-1:0] m_len = '0;
  bit m_v [ENTRIES];
  logic [VPN_W-1:0] m_vpn [ENTRIES];
  logic [ASID_W-1:0] m_asid [ENTRIES];
  logic [FRAME_W-1:0] m_frame [ENTRIES];
  int m_ptr = 0;
  bit last_hit;

  function automatic logic [FRAME_W-1:0] frame_of(logic [MA_W-1:0] a);
    return FRAME_W'(int'(a) * 37 + 5);
  endfunction
  function automatic bit ok_of(logic [MA_W-1:0] a);
    return (int'(a) % 7) != 3;
  endfunction

  task automatic chk(string r, string what, longint act, longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s act=%0h exp=%0h", r, what, act, exp);
    end
  endtask

  task automatic report();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  task automatic m_clear();
    for (int i = 0; i < ENTRIES; i++) m_v[i] = 0;
  endtask

  task automatic do_flush();
    @(negedge clk); flush = 1;
    @(negedge clk); flush = 0;
    m_clear();
  endtask

  task automatic set_base(logic [MA_W-1:0] v);
    @(negedge clk); base_we = 1; base_wdata = v;
    @(negedge clk); base_we = 0;
    m_base = v; m_clear();
  endtask

  task automatic set_len(logic [LEN_W-1:0] v);
    @(negedge clk); len_we = 1; len_wdata = v;
    @(negedge clk); len_we = 0;
    m_len = v; m_clear();
  endtask

  task automatic xlate(logic [VPN_W-1:0] vpn, logic [PAGE_W-1:0] off,
                       logic [ASID_W-1:0] asid, int lat, bit inj);
    logic [MA_W-1:0] a;
    int hi;
    bit ok;
    hi = -1;
    for (int i = 0; i < ENTRIES; i++)
      if (m_v[i] && m_vpn[i] == vpn && m_asid[i] == asid) hi = i;
    @(negedge clk);
    req_valid = 1; req_vaddr = {vpn, off}; cfg_asid = asid;
    #1;
    if ({1'b0, vpn} >= m_len) begin
      last_hit = 0;
      chk("R4", "rsp_valid", rsp_valid, 1);
      chk("R4", "fault", rsp_fault, 1);
      chk("R4", "hit", rsp_hit, 0);
      @(negedge clk); req_valid = 0; #1;
      chk("R4", "mem_req", mem_req, 0);
    end else if (hi >= 0) begin
      last_hit = 1;
      chk("R2", "rsp_valid", rsp_valid, 1);
      chk("R2", "hit", rsp_hit, 1);
      chk("R2", "fault", rsp_fault, 0);
      chk("R1", "paddr", rsp_paddr, {m_frame[hi], off});
      @(negedge clk); req_valid = 0; #1;
      chk("R2", "mem_req", mem_req, 0);
    end else begin
      last_hit = 0;
      a = m_base + MA_W'(vpn);
      ok = ok_of(a);
      chk("R3", "rsp_valid on miss", rsp_valid, 0);
      @(negedge clk); req_valid = 0; #1;
      chk("R3", "mem_req", mem_req, 1);
      chk("R3", "mem_addr", mem_addr, a);
      chk("R3", "ready", req_ready, 0);
      for (int i = 0; i < lat; i++) begin
        @(negedge clk);
        flush = inj && (i == 0);
        #1;
        if (mem_req) chk("R3", "second read", mem_req, 0);
      end
      @(negedge clk);
      flush = 0;
      if (inj) m_clear();
      mem_rsp_valid = 1; mem_rsp_data = {frame_of(a), ok};
      #1;
      chk("R3", "walk rsp_valid", rsp_valid, 1);
      chk("R3", "walk hit", rsp_hit, 0);
      chk("R5", "walk fault", rsp_fault, !ok);
      if (ok) chk("R1", "walk paddr", rsp_paddr, {frame_of(a), off});
      @(negedge clk);
      mem_rsp_valid = 0; #1;
      chk("R3", "ready after walk", req_ready, 1);
      if (ok && !inj) begin
        m_v[m_ptr] = 1; m_vpn[m_ptr] = vpn; m_asid[m_ptr] = asid;
        m_frame[m_ptr] = frame_of(a);
        m_ptr = (m_ptr + 1) % ENTRIES;
      end
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL R3 watchdog act=hung exp=done");
    report();
  end

  initial begin
    int s;
    s = $urandom(32'h5eed);
    m_clear();
    repeat (3) @(negedge clk);
    rst_n = 1;
    #1;
    chk("R12", "ready", req_ready, 1);
    chk("R12", "rsp_valid", rsp_valid, 0);
    chk("R12", "mem_req", mem_req, 0);
    xlate(8'd0, 8'h12, 4'd0, 1, 0);           // R4: length 0 after reset
    set_base(16'h0100);
    set_len(9'd64);
    xlate(8'd1, 8'h34, 4'd2, 2, 0);           // miss, refill
    xlate(8'd1, 8'hA5, 4'd2, 1, 0);           // R6 hit on refilled page
    chk("R6", "refilled page hits", last_hit, 1);
    xlate(8'd1, 8'h00, 4'd3, 1, 0);           // R7 other identifier
    chk("R7", "other asid misses", last_hit, 0);
    xlate(8'd63, 8'hFF, 4'd2, 3, 0);          // boundary inside table
    xlate(8'd64, 8'h01, 4'd2, 1, 0);          // R4 boundary outside
    xlate(8'd6, 8'h11, 4'd2, 2, 0);           // R5 invalid entry
    xlate(8'd6, 8'h11, 4'd2, 1, 0);
    chk("R5", "invalid page not stored", last_hit, 0);
    xlate(8'd1, 8'h77, 4'd2, 1, 0);
    chk("R8", "hit before flush", last_hit, 1);
    do_flush();
    xlate(8'd1, 8'h77, 4'd2, 1, 0);
    chk("R8", "miss after flush", last_hit, 0);
    set_base(16'h0200);
    xlate(8'd1, 8'h78, 4'd2, 1, 0);
    chk("R9", "miss after base write", last_hit, 0);
    set_len(9'd64);
    xlate(8'd1, 8'h79, 4'd2, 1, 0);
    chk("R9", "miss after length write", last_hit, 0);
    set_base(16'h0100);
    do_flush();
    for (int v = 30; v <= 39; v++)
      if (v != 34) xlate(VPN_W'(v), 8'h05, 4'd1, 1, 0);
    xlate(8'd32, 8'h05, 4'd1, 1, 0);
    chk("R10", "third page kept", last_hit, 1);
    xlate(8'd30, 8'h05, 4'd1, 1, 0);
    chk("R10", "first page evicted", last_hit, 0);
    xlate(8'd9, 8'h44, 4'd1, 3, 1);           // R11 flush during walk
    xlate(8'd9, 8'h44, 4'd1, 2, 0);
    chk("R11", "stale walk not stored", last_hit, 0);
    for (int n = 0; n < 400; n++) begin
      int r;
      r = $urandom % 100;
      if (r < 3) do_flush();
      else xlate(VPN_W'($urandom % 72), PAGE_W'($urandom),
                 ASID_W'($urandom % 3), 1 + ($urandom % 4), 0);
    end
    report();
  end
endmodule